// File: doc/BRIEF.md
# Delayed Hotspot Cartridge Bank Mapper

This block sits on the bus of an 8-bit CPU with a 13-bit address and decides what answers each access. When address bit 12 is set, the access goes to a 4 KB cartridge window. That window is split into four 1 KB segments. Each segment shows one 1 KB slice of an 8 KB ROM. The low part of segment 0 is taken by a 64-byte RAM, which has a read window and a separate write window. When address bit 12 is clear, the access belongs to an external I/O region, and the block only raises a flag saying that region should answer.

A read of an I/O address whose low byte is in 0x30..0x3F is a hotspot. It does not switch banks at once. It records a pending bank number, taken from the low address nibble, together with a time stamp from a free-running count of CPU cycles. The first read that comes more than the configured delay (3 cycles by default) after that stamp applies the pending bank. That same read is already decoded with the new bank. The bank picks an entry of a fixed eight-entry organisation table, which assigns a slice to every segment.

The ROM is modelled as a computed pattern with one parameter byte (a tag) per slice. A bench can therefore tell every slice apart without loading an image. Read data is registered and appears one clock after the read is presented.

Top module: `hotspot_bank_mapper`

## Requirements
- R1: After reset, no switch is pending and bank 0 is selected. Bank 0 maps segments 0,1,2,3 to slices 0,0,1,3.
- R2: A read with cpu_ce high, address bit 12 clear and low address byte 0x30..0x3F arms a pending bank equal to addr[3:0]. A write to the same address arms nothing.
- R3: A pending bank is applied by the first read whose cycle count exceeds the armed stamp by more than 3. That read already sees the new mapping. The three reads before it see the old mapping. The comparison is correct across 32-bit counter wrap.
- R4: Once a switch is applied, nothing remains pending. A hotspot read made while a switch is still pending replaces both the pending bank and the stamp.
- R5: The organisation table (slices for segments 0,1,2,3) is: bank0 0,0,1,3; bank1 0,1,2,3; bank2 4,5,6,7; bank3 7,4,2,3; bank4 0,0,6,7; bank5 0,1,7,6; bank6 2,3,4,5; bank7 6,0,5,1. A ROM byte at local offset o of slice s reads as SLICE_TAG[s] XOR o[7:0] XOR o[9:8].
- R6: Banks 8..15 select the same organisation as banks 0..7.
- R7: A cartridge read at offset 0x000..0x03F returns RAM byte addr[5:0].
- R8: A cartridge write with address bit 6 set stores wdata at RAM byte addr[5:0]. A cartridge write with bit 6 clear leaves the RAM unchanged.
- R9: A read at offset 0x040..0x07F returns 0xFF and leaves the RAM unchanged.
- R10: Segment 0 returns ROM data from local offset 0x080 upward.
- R11: Segment 3 local offset 0x3FC always reads 0x00.
- R12: io_sel is high exactly when cpu_ce is high, a read or write is presented and address bit 12 is clear. Reads in the I/O region return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ce | input | 1 | One pulse per CPU cycle; qualifies accesses and advances the cycle count |
| addr | input | 13 | CPU address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid the clock after a read |
| io_sel | output | 1 | The I/O region should answer this access |

## Verification
The bench places the hotspot stamp two counts before the counter wraps. It then checks that the three following reads still see the old mapping and that the fourth sees the new one. A comparison that ignores wrap would either never switch or switch early. The bench walks all eight table entries plus two aliased banks, so a wrong table entry, or a bank bit 3 that leaks into the lookup, shows up as a wrong slice tag. A second hotspot is issued while a switch is still pending, which catches a design that keeps the first bank or the first stamp. The RAM ports, the 0x080 start of segment 0 and the forced zero at 0x3FC are each read directly, so a stray write, a lost boundary or a missing override returns a wrong byte.

// File: rtl/hsbm_pkg.sv
// Shared constants, the access-region type and the bank organisation table
// for the delayed hotspot bank mapper. Assumes eight 1 KB slices and four
// 1 KB segments in the cartridge window.
package hsbm_pkg;

    localparam int SLICES  = 8;
    localparam int SEGS    = 4;
    localparam int SLICE_W = $clog2(SLICES);
    localparam int SEG_W   = $clog2(SEGS);
    localparam int OFF_W   = 10;
    localparam int BANK_W  = 4;

    typedef enum logic [2:0] {
        RG_IO,
        RG_RAM_RD,
        RG_RAM_WP,
        RG_ROM,
        RG_ZERO
    } region_t;

    // Slice shown in a segment for a given organisation index.
    function automatic logic [SLICE_W-1:0] org_slice(input logic [2:0] org,
                                                     input logic [SEG_W-1:0] seg);
        logic [4*SLICE_W-1:0] row;
        case (org)
            3'd0:    row = {3'd3, 3'd1, 3'd0, 3'd0};
            3'd1:    row = {3'd3, 3'd2, 3'd1, 3'd0};
            3'd2:    row = {3'd7, 3'd6, 3'd5, 3'd4};
            3'd3:    row = {3'd3, 3'd2, 3'd4, 3'd7};
            3'd4:    row = {3'd7, 3'd6, 3'd0, 3'd0};
            3'd5:    row = {3'd6, 3'd7, 3'd1, 3'd0};
            3'd6:    row = {3'd5, 3'd4, 3'd3, 3'd2};
            default: row = {3'd1, 3'd5, 3'd0, 3'd6};
        endcase
        return row[seg*SLICE_W +: SLICE_W];
    endfunction

endpackage

// File: rtl/hsbm_bank_ctrl.sv
// Bank controller: keeps a free-running cycle count, arms a pending bank on a
// hotspot read and applies it on the first read more than DELAY counts after
// the stamp. Assumes the caller qualifies rd_acc and hot with cpu_ce.
module hsbm_bank_ctrl #(
    parameter int          CNT_W     = 32,
    parameter int          DELAY     = 3,
    parameter logic [CNT_W-1:0] CNT_START = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce,
    input  logic       rd_acc,
    input  logic       hot,
    input  logic [3:0] hot_bank,
    output logic [2:0] org
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] stamp;
    logic [CNT_W-1:0] elapsed;
    logic             pend_valid;
    logic [3:0]       pend_bank;
    logic [3:0]       cur_bank;
    logic [3:0]       eff_bank;
    logic             due;

    // Modular difference keeps the delay test correct across counter wrap.
    always_comb begin
        elapsed  = cnt - stamp;
        due      = rd_acc && pend_valid && (elapsed > CNT_W'(DELAY));
        eff_bank = due ? pend_bank : cur_bank;
        org      = eff_bank[2:0];
    end

    // Free-running cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= CNT_START;
        else if (ce) cnt <= cnt + 1'b1;
    end

    // Pending-switch and current-bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_bank  <= '0;
            stamp      <= '0;
            cur_bank   <= '0;
        end else begin
            if (due) begin
                cur_bank   <= pend_bank;
                pend_valid <= 1'b0;
            end
            if (hot) begin
                pend_valid <= 1'b1;
                pend_bank  <= hot_bank;
                stamp      <= cnt;
            end
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_bank == 4'd0 && !pend_valid));

    p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hot |=> (pend_valid && pend_bank == $past(hot_bank) && stamp == $past(cnt)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && pend_valid && (cnt - stamp) <= CNT_W'(DELAY)) |=> $stable(cur_bank));

    p_switch_needs_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_bank) |-> ($past(pend_valid) && $past(rd_acc)));

endmodule

// File: rtl/hsbm_win_decode.sv
// Window decoder: classifies an address into I/O, RAM read port, RAM write
// port, forced-zero byte or ROM, and finds the ROM slice for the segment
// from the current organisation. Purely combinational.
module hsbm_win_decode
    import hsbm_pkg::*;
(
    input  logic [12:0]        addr,
    input  logic [2:0]         org,
    output region_t            region,
    output logic [SLICE_W-1:0] slice
);

    localparam logic [OFF_W-1:0] ZERO_OFF = OFF_W'(10'h3FC);

    logic [SLICE_W-1:0] seg_slice [SEGS];
    logic [SEG_W-1:0]   seg;
    logic [OFF_W-1:0]   off;

    // One table lookup per segment.
    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        assign seg_slice[s] = org_slice(org, SEG_W'(s));
    end

    // Region classification and slice selection.
    always_comb begin
        seg   = addr[11:10];
        off   = addr[9:0];
        slice = seg_slice[seg];
        if (!addr[12])                               region = RG_IO;
        else if (seg == '0 && off[9:6] == 4'd0)      region = RG_RAM_RD;
        else if (seg == '0 && off[9:6] == 4'd1)      region = RG_RAM_WP;
        else if (seg == SEG_W'(SEGS-1) && off == ZERO_OFF) region = RG_ZERO;
        else                                         region = RG_ROM;
    end

endmodule

// File: rtl/hsbm_rom_model.sv
// Computed ROM model: each slice is a pattern derived from its tag byte, so
// every slice and offset can be told apart without a stored image.
module hsbm_rom_model
    import hsbm_pkg::*;
#(
    parameter logic [7:0] SLICE_TAG [SLICES] = '{8'h00, 8'h24, 8'h48, 8'h6C,
                                                8'h90, 8'hB4, 8'hD8, 8'hFC}
) (
    input  logic [SLICE_W-1:0] slice,
    input  logic [OFF_W-1:0]   off,
    output logic [7:0]         data
);

    // Pattern byte for the addressed slice and offset.
    always_comb data = SLICE_TAG[slice] ^ off[7:0] ^ {6'b0, off[9:8]};

endmodule

// File: rtl/hotspot_bank_mapper.sv
// Top of the delayed hotspot bank mapper: decodes each CPU access, holds the
// 64-byte RAM and registers read data one clock after the read. Assumes at
// most one access per cpu_ce pulse.
module hotspot_bank_mapper
    import hsbm_pkg::*;
#(
    parameter int               CNT_W        = 32,
    parameter int               SWITCH_DELAY = 3,
    parameter logic [CNT_W-1:0] CNT_START    = '0,
    parameter logic [7:0]       SLICE_TAG [SLICES] = '{8'h00, 8'h24, 8'h48, 8'h6C,
                                                      8'h90, 8'hB4, 8'hD8, 8'hFC},
    parameter int               RAM_BYTES    = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_ce,
    input  logic [12:0] addr,
    input  logic        rd,
    input  logic        wr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        io_sel
);

    localparam int RAM_AW = $clog2(RAM_BYTES);

    logic               rd_acc;
    logic               hot;
    logic [2:0]         org;
    region_t            region;
    logic [SLICE_W-1:0] slice;
    logic [7:0]         rom_q;
    logic [7:0]         ram [RAM_BYTES];

    // Access qualification and the I/O answer flag.
    always_comb begin
        rd_acc = cpu_ce && rd;
        hot    = rd_acc && !addr[12] && addr[7:4] == 4'h3;
        io_sel = cpu_ce && (rd || wr) && !addr[12];
    end

    hsbm_bank_ctrl #(
        .CNT_W     (CNT_W),
        .DELAY     (SWITCH_DELAY),
        .CNT_START (CNT_START)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (cpu_ce),
        .rd_acc   (rd_acc),
        .hot      (hot),
        .hot_bank (addr[3:0]),
        .org      (org)
    );

    hsbm_win_decode u_dec (
        .addr   (addr),
        .org    (org),
        .region (region),
        .slice  (slice)
    );

    hsbm_rom_model #(
        .SLICE_TAG (SLICE_TAG)
    ) u_rom (
        .slice (slice),
        .off   (addr[9:0]),
        .data  (rom_q)
    );

    // RAM write port: any cartridge write with address bit 6 set.
    always_ff @(posedge clk) begin
        if (cpu_ce && wr && addr[12] && addr[6])
            ram[addr[RAM_AW-1:0]] <= wdata;
    end

    // Registered read data, selected by region.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= 8'hFF;
        else if (rd_acc) begin
            case (region)
                RG_RAM_RD: rdata <= ram[addr[RAM_AW-1:0]];
                RG_ROM:    rdata <= rom_q;
                RG_ZERO:   rdata <= 8'h00;
                default:   rdata <= 8'hFF;
            endcase
        end
    end

    p_wport_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && rd && addr[12] && addr[11:6] == 6'b000001) |=> rdata == 8'hFF);

    p_forced_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ce && rd && addr == 13'h1FFC) |=> rdata == 8'h00);

    p_io_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && rd) |=> rdata == 8'hFF);

    p_io_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> !addr[12]);

endmodule

// File: tb/hotspot_bank_mapper_test.sv
module hotspot_bank_mapper_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] TAGS [8] = '{8'h11, 8'h2E, 8'h43, 8'h5C,
                                        8'h67, 8'h8A, 8'h9D, 8'hC6};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b1;
    logic [12:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        io_sel;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hotspot_bank_mapper #(
        .CNT_START (32'hFFFF_FFFE),
        .SLICE_TAG (TAGS)
    ) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cpu_ce (cpu_ce),
        .addr   (addr),
        .rd     (rd),
        .wr     (wr),
        .wdata  (wdata),
        .rdata  (rdata),
        .io_sel (io_sel)
    );

    function automatic int exp_slice(input int b, input int s);
        int t [8][4] = '{'{0,0,1,3}, '{0,1,2,3}, '{4,5,6,7}, '{7,4,2,3},
                         '{0,0,6,7}, '{0,1,7,6}, '{2,3,4,5}, '{6,0,5,1}};
        return t[b % 8][s];
    endfunction

    function automatic logic [7:0] exp_rom(input int sl, input logic [9:0] o);
        return TAGS[sl] ^ o[7:0] ^ {6'b0, o[9:8]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One read: presented for exactly one rising edge, data sampled after it.
    task automatic rd_op(input logic [12:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        d = rdata; rd = 1'b0;
    endtask

    task automatic wr_op(input logic [12:0] a, input logic [7:0] v);
        addr = a; wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_switch(input int b);
        logic [7:0] d;
        rd_op(13'h0030 | 13'(b), d);
        repeat (4) rd_op(13'h1000, d);
    endtask

    task automatic chk_bank(input int b, input string req);
        logic [7:0] d;
        for (int s = 0; s < 4; s++) begin
            rd_op({1'b1, 2'(s), 10'h1A5}, d);
            chk(req, d, exp_rom(exp_slice(b, s), 10'h1A5));
        end
    endtask

    // R3 across counter wrap: stamp FFFFFFFE, switch at count 2.
    task automatic t_wrap_delay();
        logic [7:0] d;
        addr = 13'h0032; rd = 1'b1;
        #1;
        checks++;
        if (io_sel !== 1'b1) begin
            failures++;
            $display("FAIL R12 io_sel actual=%b expected=1", io_sel);
        end
        @(negedge clk);
        d = rdata; rd = 1'b0;
        chk("R12 io read", d, 8'hFF);
        for (int i = 0; i < 3; i++) begin
            rd_op(13'h1410, d);
            chk("R3 before delay", d, exp_rom(0, 10'h010));
        end
        rd_op(13'h1410, d);
        chk("R3 switch read", d, exp_rom(5, 10'h010));
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        do_reset();
        chk_bank(0, "R1 bank0");
        repeat (6) rd_op(13'h1000, d);
        chk_bank(0, "R1 no pending");
    endtask

    task automatic t_table();
        for (int b = 0; b < 8; b++) begin
            do_switch(b);
            chk_bank(b, "R5 table");
        end
    endtask

    task automatic t_alias();
        do_switch(11);
        chk_bank(3, "R6 alias 11");
        do_switch(15);
        chk_bank(7, "R6 alias 15");
    endtask

    task automatic t_rearm();
        logic [7:0] d;
        do_switch(2);
        rd_op(13'h0036, d);
        rd_op(13'h1000, d);
        rd_op(13'h1000, d);
        rd_op(13'h0033, d);
        for (int i = 0; i < 3; i++) begin
            rd_op(13'h1510, d);
            chk("R4 rearm hold", d, exp_rom(5, 10'h110));
        end
        rd_op(13'h1510, d);
        chk("R4 rearm apply", d, exp_rom(4, 10'h110));
        repeat (5) rd_op(13'h1000, d);
        chk_bank(3, "R4 cleared");
        wr_op(13'h0035, 8'h00);
        repeat (5) rd_op(13'h1000, d);
        chk_bank(3, "R2 write no arm");
    endtask

    task automatic t_ram();
        logic [7:0] d;
        wr_op(13'h1045, 8'h5A);
        rd_op(13'h1005, d);
        chk("R7 R8 ram store", d, 8'h5A);
        wr_op(13'h1005, 8'h33);
        rd_op(13'h1005, d);
        chk("R8 bit6 clear discarded", d, 8'h5A);
        rd_op(13'h1045, d);
        chk("R9 wport read", d, 8'hFF);
        rd_op(13'h1005, d);
        chk("R9 ram unchanged", d, 8'h5A);
        wr_op(13'h107F, 8'hC3);
        rd_op(13'h103F, d);
        chk("R7 top byte", d, 8'hC3);
    endtask

    task automatic t_boundaries();
        logic [7:0] d;
        do_switch(1);
        rd_op(13'h1080, d);
        chk("R10 seg0 0x080", d, exp_rom(0, 10'h080));
        rd_op(13'h107F, d);
        chk("R10 below 0x080", d, 8'hFF);
        rd_op(13'h1FFC, d);
        chk("R11 forced zero", d, 8'h00);
        rd_op(13'h1FFB, d);
        chk("R11 neighbour", d, exp_rom(3, 10'h3FB));
        rd_op(13'h1FFD, d);
        chk("R11 neighbour", d, exp_rom(3, 10'h3FD));
        addr = 13'h1200; rd = 1'b1;
        #1;
        checks++;
        if (io_sel !== 1'b0) begin
            failures++;
            $display("FAIL R12 cart io_sel actual=%b expected=0", io_sel);
        end
        @(negedge clk);
        rd = 1'b0;
        rd_op(13'h0F80, d);
        chk("R12 io read", d, 8'hFF);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_wrap_delay();
        t_reset_state();
        t_table();
        t_alias();
        t_rearm();
        t_ram();
        t_boundaries();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule